// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a computer-operating-properly watchdog. It counts bus clock cycles while its enable input is high. If software has not serviced it within a fixed window of 2^17 cycles, it raises a one-cycle reset request. At a 2 MHz bus clock, which is the crystal frequency halved, this window is about 65.5 ms.

Software services the watchdog by writing a value with bit 0 clear to one fixed address on the system bus. A write to that address with bit 0 set does nothing. The watchdog never drives data for that address. Reads always return the memory data supplied from outside, so the service location can keep ordinary read-only content. After each timeout the count restarts from zero, so a stalled program receives repeated requests at the same interval.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, `rst_req` is low and the count is held at zero. The first timeout after release comes exactly 2^TIMEOUT_LOG2 enabled cycles after release.
- R2: `rst_req` goes high on the clock edge that completes 2^TIMEOUT_LOG2 enabled cycles since the last clear. With the default TIMEOUT_LOG2 = 17, that is 131072 cycles.
- R3: `rst_req` is high for exactly one cycle. The count then restarts from zero, so with no service the next request comes 2^TIMEOUT_LOG2 enabled cycles later.
- R4: A write (`bus_wr` = 1) to `bus_addr` = SVC_ADDR with `bus_wdata[0]` = 0 clears the count on that edge. The other data bits are don't-care. The next request then comes 2^TIMEOUT_LOG2 enabled cycles after that edge. A service write clears the count even when `en` is low.
- R5: A write to SVC_ADDR with `bus_wdata[0]` = 1 has no effect on the count or on the time of the next request.
- R6: A write of any value to an address other than SVC_ADDR has no effect on the count.
- R7: While `en` is low, the count holds its value and `rst_req` stays low. Counting resumes where it stopped.
- R8: If a service write lands on the same edge that would complete the window, the service wins. No request is raised, and a full new window starts.
- R9: `bus_rdata` always equals `mem_rdata`, for every address including SVC_ADDR, whether or not a write is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| en | input | 1 | Counting enable |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| mem_rdata | input | DATA_W | Memory read data from outside the block |
| bus_rdata | output | DATA_W | Read data returned to the bus |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
On every cycle, the assertions check four things:
- the request is a single-cycle pulse;
- no request follows a service write or a disabled cycle;
- every request lands exactly one full window after the last clear, measured by an independent interval counter;
- that counter never passes the window.

Only the bench's scenarios can show the rest:
- a write with bit 0 set, or a write to a neighbouring address, leaves the timeout time unchanged;
- a pause stretches the window by exactly the paused cycles;
- read data passes through untouched at the service address.

The bench checks each of these by the absolute cycle at which the request appears.

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          TIMEOUT_LOG2 = 17,
  parameter logic [15:0] SVC_ADDR     = 16'h1FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] SVC = ADDR_W'(SVC_ADDR);

  logic [TIMEOUT_LOG2-1:0] count;
  logic                    svc_clr;
  logic                    terminal;

  assign svc_clr   = bus_wr && (bus_addr == SVC) && !bus_wdata[0];
  assign terminal  = en && (&count);
  assign bus_rdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= terminal && !svc_clr;
      if (svc_clr)
        count <= '0;
      else if (en)
        count <= count + 1'b1;
    end
  end
endmodule

module cop_watchdog_chk #(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          TIMEOUT_LOG2 = 17,
  parameter logic [15:0] SVC_ADDR     = 16'h1FF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req
);
  localparam logic [TIMEOUT_LOG2:0] PERIOD = (TIMEOUT_LOG2+1)'(1) << TIMEOUT_LOG2;

  logic                  svc_hit;
  logic [TIMEOUT_LOG2:0] gap;

  assign svc_hit = bus_wr && (bus_addr == ADDR_W'(SVC_ADDR)) && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap <= '0;
    else if (svc_hit) gap <= '0;
    else if (rst_req) gap <= en ? 1 : 0;
    else if (en)      gap <= gap + 1'b1;
  end

  assert_timeout_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> gap == PERIOD);
  assert_gap_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= PERIOD);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_service_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> !rst_req);
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_req);
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_LOG2(TIMEOUT_LOG2), .SVC_ADDR(SVC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .rst_req(rst_req)
);

// File: tb/cop_watchdog_test.sv
module cop_watchdog_test;
  localparam logic [15:0] SVC = 16'h1FF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc;
  int   checks = 0;
  int   fails  = 0;

  logic        en_b = 1'b1, wr_b = 1'b0;
  logic [15:0] addr_b = 16'h0000;
  logic [7:0]  wd_b = 8'h00, mem_b = 8'h00;
  logic [7:0]  rd_b;
  logic        req_b;

  logic        en_s = 1'b1, wr_s = 1'b0;
  logic [15:0] addr_s = 16'h0000;
  logic [7:0]  wd_s = 8'h00, mem_s = 8'h00;
  logic [7:0]  rd_s;
  logic        req_s;

  int q_b[$];
  int q_s[$];

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  cop_watchdog uut (
    .clk(clk), .rst_n(rst_n), .en(en_b), .bus_addr(addr_b), .bus_wr(wr_b),
    .bus_wdata(wd_b), .mem_rdata(mem_b), .bus_rdata(rd_b), .rst_req(req_b)
  );

  cop_watchdog #(.TIMEOUT_LOG2(4)) uut_s (
    .clk(clk), .rst_n(rst_n), .en(en_s), .bus_addr(addr_s), .bus_wr(wr_s),
    .bus_wdata(wd_s), .mem_rdata(mem_s), .bus_rdata(rd_s), .rst_req(req_s)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard monitors: compare each pulse against the queued expected edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_b.size() > 0 && q_b[0] < cyc) begin
        check(1'b0, "R2/R5/R6/R7 big: missed request", cyc, q_b[0]);
        void'(q_b.pop_front());
      end
      if (req_b) begin
        if (q_b.size() == 0) check(1'b0, "R3/R5/R6 big: unexpected request", cyc, -1);
        else check(q_b.pop_front() == cyc, "R2 big: request edge", cyc, cyc);
      end
      if (q_s.size() > 0 && q_s[0] < cyc) begin
        check(1'b0, "R3/R4/R8 small: missed request", cyc, q_s[0]);
        void'(q_s.pop_front());
      end
      if (req_s) begin
        if (q_s.size() == 0) check(1'b0, "R8/R7 small: unexpected request", cyc, -1);
        else check(q_s.pop_front() == cyc, "R3/R4 small: request edge", cyc, cyc);
      end
    end
  end

  task automatic at_edge(input int n);
    @(negedge clk iff cyc == n - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_b == 1'b0, "R1 reset big", req_b, 0);
    check(req_s == 1'b0, "R1 reset small", req_s, 0);

    // R9 read passthrough at several addresses
    addr_b = SVC; mem_b = 8'h5A; #1;
    check(rd_b == 8'h5A, "R9 read svc", rd_b, 8'h5A);
    mem_b = 8'hC3; #1;
    check(rd_b == 8'hC3, "R9 read svc 2", rd_b, 8'hC3);
    addr_b = 16'h0100; mem_b = 8'h17; #1;
    check(rd_b == 8'h17, "R9 read other", rd_b, 8'h17);
    addr_b = 16'h0000;

    // Expected pulses. Big: 131072 + 40 paused edges. Small: 16, 32, 56, 88.
    q_b.push_back(131072 + 40);
    q_s.push_back(16); q_s.push_back(32); q_s.push_back(56); q_s.push_back(88);

    @(negedge clk);
    rst_n = 1'b1;

    // Small R4: service at edge 40 with other data bits set
    at_edge(40); wr_s = 1'b1; addr_s = SVC; wd_s = 8'hFE;
    @(negedge clk); wr_s = 1'b0;
    // Small R8: service exactly on the terminal edge 72
    at_edge(72); wr_s = 1'b1; addr_s = SVC; wd_s = 8'h00;
    @(negedge clk); wr_s = 1'b0;
    // Small R7: disable after the pulse at 88, so no further pulses
    at_edge(89); en_s = 1'b0;

    // Big R5: write with bit 0 set to the service address, and read during the write (R9)
    at_edge(1000); wr_b = 1'b1; addr_b = SVC; wd_b = 8'h01; mem_b = 8'h99; #1;
    check(rd_b == 8'h99, "R9 read during write", rd_b, 8'h99);
    @(negedge clk); wr_b = 1'b0;
    // Big R6: write bit0 = 0 to neighbouring addresses
    at_edge(2000); wr_b = 1'b1; addr_b = SVC + 16'd1; wd_b = 8'h00;
    @(negedge clk); addr_b = SVC - 16'd1;
    @(negedge clk); wr_b = 1'b0;
    // Big R7: pause for 40 edges (3001..3040)
    at_edge(3001); en_b = 1'b0;
    at_edge(3041); en_b = 1'b1;

    at_edge(131072 + 40 - 1);
    check(req_b == 1'b0, "R2 no early request", req_b, 0);
    at_edge(131200);
    check(q_b.size() == 0, "R2/R7 big queue drained", q_b.size(), 0);
    check(q_s.size() == 0, "R3/R4/R8 small queue drained", q_s.size(), 0);
    check(req_s == 1'b0, "R7 small held off", req_s, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule